// File: doc/BRIEF.md
# Offset Magnitude Comparator with Overflow

This block compares an unsigned operand A against a second unsigned operand B increased by one. It raises five relation flags (greater, greater-or-equal, less, less-or-equal, equal) describing how A stands relative to B+1. A sixth flag reports when B+1 no longer fits in the operand width. In that case every relation flag is held low, because the reference value cannot be represented.

Operand width is a parameter (default 4). The flags come from one combinational procedure in which the overflow test is evaluated first. An optional output register stage (parameter `OUT_REG`, default 1) holds the flags for one clock and clears them under a synchronous active-high reset. With `OUT_REG` = 0 the flags follow the operands with no clock involved.

Top module: `offset_cmp`

## Requirements
- R1: The reference value is B+1, formed in WIDTH+1 bits, and is never B itself. For example A=6, B=5 raises the equal flag, and A=5, B=5 raises the less flag.
- R2: The overflow flag `ovf_o` is 1 exactly when B is all ones (15 at the default width), whatever the value of A.
- R3: While `ovf_o` is 1, all five relation flags are 0.
- R4: While `ovf_o` is 0, exactly one of `gt_o`, `eq_o`, `lt_o` is 1, and it matches the true unsigned relation of A to B+1.
- R5: While `ovf_o` is 0, `ge_o` equals `gt_o` OR `eq_o`, and `le_o` equals `lt_o` OR `eq_o`.
- R6: With A=9 and B=5, only `gt_o` and `ge_o` are 1. All other outputs, overflow included, are 0.
- R7: With `OUT_REG` = 1, the flags for the operands present at a rising clock edge appear right after that edge and stay unchanged until the next edge.
- R8: With `OUT_REG` = 1, a rising edge with `rst` high drives all six outputs to 0, whatever the operands are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst | input | 1 | Synchronous active-high reset of the output stage |
| a_in | input | WIDTH | Operand A, unsigned |
| b_in | input | WIDTH | Operand B, unsigned; the comparison uses B+1 |
| gt_o | output | 1 | A greater than B+1 |
| ge_o | output | 1 | A greater than or equal to B+1 |
| lt_o | output | 1 | A less than B+1 |
| le_o | output | 1 | A less than or equal to B+1 |
| eq_o | output | 1 | A equal to B+1 |
| ovf_o | output | 1 | B+1 does not fit in WIDTH bits |

## Verification
Two functions can act in the same cycle. The reset clears the output register, and the overflow path wants to raise `ovf_o`. The bench provokes this by holding B at all ones while `rst` is high, and it expects all six outputs to be 0: reset wins, with no overflow flag. A second overlap occurs when overflow suppresses a relation that would otherwise hold. The full sweep puts A = 15 with B = 15, and there the bench expects only `ovf_o`, never `gt_o` or `ge_o`.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;

    typedef struct packed {
        logic gt;
        logic ge;
        logic lt;
        logic le;
        logic eq;
        logic ovf;
    } ocmp_flags_t;

    localparam ocmp_flags_t FLAGS_CLEAR = '0;

endpackage

// File: rtl/ocmp_incr.sv
module ocmp_incr #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] b_val,
    output logic [WIDTH-1:0] sum_val,
    output logic             carry
);
    localparam int EXT = WIDTH + 1;

    logic [EXT-1:0] wide;

    always_comb begin
        wide    = {1'b0, b_val} + EXT'(1);
        sum_val = wide[WIDTH-1:0];
        carry   = wide[WIDTH];
    end
endmodule

// File: rtl/ocmp_relate.sv
module ocmp_relate
    import ocmp_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a_val,
    input  logic [WIDTH-1:0] ref_val,
    input  logic             carry,
    output ocmp_flags_t      flags
);
    always_comb begin
        flags = FLAGS_CLEAR;
        if (carry) begin
            flags.ovf = 1'b1;
        end else if (a_val > ref_val) begin
            flags.gt = 1'b1;
            flags.ge = 1'b1;
        end else if (a_val == ref_val) begin
            flags.eq = 1'b1;
            flags.ge = 1'b1;
            flags.le = 1'b1;
        end else begin
            flags.lt = 1'b1;
            flags.le = 1'b1;
        end
    end
endmodule

// File: rtl/offset_cmp.sv
module offset_cmp
    import ocmp_pkg::*;
#(
    parameter int WIDTH   = 4,
    parameter bit OUT_REG = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic             gt_o,
    output logic             ge_o,
    output logic             lt_o,
    output logic             le_o,
    output logic             eq_o,
    output logic             ovf_o
);
    logic [WIDTH-1:0] ref_val;
    logic             carry;
    ocmp_flags_t      comb_flags;
    ocmp_flags_t      out_flags;

    ocmp_incr #(.WIDTH(WIDTH)) u_incr (
        .b_val   (b_in),
        .sum_val (ref_val),
        .carry   (carry)
    );

    ocmp_relate #(.WIDTH(WIDTH)) u_relate (
        .a_val   (a_in),
        .ref_val (ref_val),
        .carry   (carry),
        .flags   (comb_flags)
    );

    generate
        if (OUT_REG) begin : g_reg
            ocmp_flags_t flags_q;
            always_ff @(posedge clk) begin
                if (rst) flags_q <= FLAGS_CLEAR;
                else     flags_q <= comb_flags;
            end
            assign out_flags = flags_q;
        end else begin : g_comb
            assign out_flags = comb_flags;
        end
    endgenerate

    assign gt_o  = out_flags.gt;
    assign ge_o  = out_flags.ge;
    assign lt_o  = out_flags.lt;
    assign le_o  = out_flags.le;
    assign eq_o  = out_flags.eq;
    assign ovf_o = out_flags.ovf;

    // Checks on the outputs
    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    p_ovf_zeroes_r3: assert property (@(posedge clk) disable iff (rst)
        ovf_o |-> !(gt_o || ge_o || lt_o || le_o || eq_o));

    p_one_relation_r4: assert property (@(posedge clk) disable iff (rst)
        (armed && !ovf_o) |-> ($countones({gt_o, eq_o, lt_o}) == 1));

    p_ge_le_r5: assert property (@(posedge clk) disable iff (rst)
        !ovf_o |-> (ge_o == (gt_o || eq_o)) && (le_o == (lt_o || eq_o)));

    generate
        if (OUT_REG) begin : g_reg_chk
            p_ovf_tracks_b_r2: assert property (@(posedge clk) disable iff (rst)
                armed |-> (ovf_o == ($past(b_in) == '1)));
            p_reset_clear_r8: assert property (@(posedge clk)
                $past(rst) |-> !(gt_o || ge_o || lt_o || le_o || eq_o || ovf_o));
        end else begin : g_comb_chk
            p_ovf_tracks_b_r2: assert property (@(posedge clk) disable iff (rst)
                ovf_o == (b_in == '1));
        end
    endgenerate
endmodule

// File: tb/sim_offset_cmp.sv
module sim_offset_cmp;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic gt_o, ge_o, lt_o, le_o, eq_o, ovf_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    offset_cmp #(.WIDTH(W), .OUT_REG(1'b1)) u0 (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
        .gt_o(gt_o), .ge_o(ge_o), .lt_o(lt_o), .le_o(le_o),
        .eq_o(eq_o), .ovf_o(ovf_o)
    );

    // Order of packing: gt ge lt le eq ovf
    function automatic logic [5:0] model(input int a, input int b);
        int r;
        r = b + 1;
        if (r >= (1 << W)) return 6'b000001;
        if (a > r)  return 6'b110000;
        if (a == r) return 6'b010110;
        return 6'b001100;
    endfunction

    task automatic check(input string req, input logic [5:0] exp);
        logic [5:0] got;
        got = {gt_o, ge_o, lt_o, le_o, eq_o, ovf_o};
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s a=%0d b=%0d got=%b exp=%b", req, a_in, b_in, got, exp);
        end
    endtask

    // Drive at negedge, capture at posedge, sample 2 ns after it
    task automatic apply(input int a, input int b, input string req);
        @(negedge clk);
        a_in = W'(a);
        b_in = W'(b);
        @(posedge clk);
        #2;
        check(req, model(a, b));
    endtask

    initial begin
        // R8 and overflow in the same reset cycle
        b_in = '1;
        a_in = '1;
        repeat (3) @(posedge clk);
        #2;
        check("R8", 6'b000000);
        @(negedge clk);
        rst = 1'b0;

        apply(9, 5, "R6");
        apply(6, 5, "R1");
        apply(5, 5, "R1");
        apply(0, 15, "R2");
        apply(15, 15, "R3");

        // R7: the held value survives an operand change before the next edge
        @(negedge clk);
        a_in = 4'd3;
        b_in = 4'd1;
        @(posedge clk);
        #2;
        a_in = 4'd12;
        #5;
        check("R7", model(3, 1));

        for (int a = 0; a < (1 << W); a++)
            for (int b = 0; b < (1 << W); b++)
                apply(a, b, "R4/R5");

        // R8 again, after activity: reset with a valid relation pending
        @(negedge clk);
        rst = 1'b1;
        a_in = 4'd9;
        b_in = 4'd2;
        @(posedge clk);
        #2;
        check("R8", 6'b000000);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule